// File: doc/BRIEF.md
# Three-Wire Serial Register Bus Slave

This block is a slave for a serial register bus with three pins: an active-low select, a bus clock and one data line. The block runs on the system clock and oversamples all three pins. A frame opens with a 9-bit header that names a device, a direction and a register. A single 16-bit word follows, and it moves either from the master to the slave or from the slave to the master.

On the chip side the block offers a simple parallel access port to a register file. That port carries the device address, the register index, a read flag, the write word, a read-data return and a one-cycle strobe. The slave answers only to its own configured device address. On a read it fetches the register as soon as the header is complete and turns the data pin around. On a write it collects all sixteen bits before it issues the access. After every data phase it falls back to header reception, so several frames can run inside one select window.

Top module: `twr_slave`

## Requirements
- R1: While select is high the slave sits in the header phase with a zero bit count and a zero shift value, and releases the data pin. A frame cut short by select going high issues no access.
- R2: Data bits are taken only at a rising edge of the bus clock while select is low, most significant bit first. Changes of the data pin between rising edges have no effect on the captured word.
- R3: The header is 9 bits. Bits [8:6] are the device address, bit [5] is the direction (1 = read) and bits [4:0] are the register index. These fields appear on regDev, regRead and regIdx once the header is complete.
- R4: On a read that matches, regStrobe pulses for one cycle with regRead=1 right after the 9th rising edge, and regRdata is latched in that cycle. The data pin is then driven, and each of the next 16 rising edges puts the next bit of the latched word on busDatOut, MSB first.
- R5: On a write that matches, the 16 data bits are shifted in. regStrobe pulses for one cycle with regRead=0 only after the 16th data bit, and regWdata holds the full word during that cycle.
- R6: After the 16th data bit the slave returns to the header phase, with select still low, and accepts a further frame.
- R7: When the header's device address differs from the DEV_ID parameter (default 1), no strobe is issued and busDatOe stays low for the whole frame.
- R8: After the last bit of a read, busDatOe stays high until the next rising bus clock edge or until select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus select, active low |
| busClk | input | 1 | Bus clock from the master |
| busDatIn | input | 1 | Data pin as seen by the slave |
| busDatOut | output | 1 | Data value the slave drives on reads |
| busDatOe | output | 1 | Data pin output enable |
| regDev | output | 3 | Device address of the current header |
| regIdx | output | 5 | Register index of the current header |
| regRead | output | 1 | 1 = read access, 0 = write access |
| regWdata | output | 16 | Write word, valid during a write strobe |
| regRdata | input | 16 | Read word from the register file, sampled during a read strobe |
| regStrobe | output | 1 | One-cycle access strobe |

## Verification
The assertions and the checks rely on four assumptions about the inputs. Each bus clock level lasts several system clocks, longer than the synchronizer depth plus two. The data pin is steady from before a rising bus clock edge until a few system clocks after it. Select only changes while the bus clock is low. regRdata follows regIdx without delay. The bench models a master that holds each bus clock level for six system clocks and moves select only with the bus clock low. In its noisy write it flips the data pin three cycles after each rising edge, well after the synchronized edge has been taken. Its register file answers the read combinationally from regIdx.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic {PH_HDR = 1'b0, PH_DATA = 1'b1} phase_t;

  typedef struct packed {
    logic clear;
    logic shiftIn;
    logic shiftOut;
    logic loadRd;
    logic latchHdr;
  } dpCtl_t;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= din;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= stage[g-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/twr_ctrl.sv
module twr_ctrl
  import twr_pkg::*;
#(
  parameter int HDR_BITS = 9,
  parameter int DATA_BITS = 16,
  parameter int DEV_BITS = 3,
  parameter logic [DEV_BITS-1:0] DEV_ID = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selS,
  input  logic                clkS,
  input  logic [DEV_BITS-1:0] hdrDev,
  input  logic                hdrRd,
  output dpCtl_t              ctl,
  output logic                regStrobe,
  output logic                busDatOe
);
  localparam int MAXB  = (DATA_BITS > HDR_BITS) ? DATA_BITS : HDR_BITS;
  localparam int CNT_W = $clog2(MAXB);

  logic             clkPrev;
  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;
  logic             isRead, isMatch, strobeQ, holdQ;
  logic             rise, hdrDone, dataDone;

  assign rise     = clkS & ~clkPrev & ~selS;
  assign hdrDone  = rise && phase == PH_HDR  && bitCnt == CNT_W'(HDR_BITS-1);
  assign dataDone = rise && phase == PH_DATA && bitCnt == CNT_W'(DATA_BITS-1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      phase   <= PH_HDR;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      isMatch <= 1'b0;
      strobeQ <= 1'b0;
      holdQ   <= 1'b0;
    end else begin
      clkPrev <= clkS;
      strobeQ <= 1'b0;
      if (selS) begin
        phase  <= PH_HDR;
        bitCnt <= '0;
        holdQ  <= 1'b0;
      end else if (rise) begin
        holdQ <= 1'b0;
        if (phase == PH_HDR) begin
          if (hdrDone) begin
            phase   <= PH_DATA;
            bitCnt  <= '0;
            isRead  <= hdrRd;
            isMatch <= (hdrDev == DEV_ID);
            strobeQ <= hdrRd && (hdrDev == DEV_ID);
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end else begin
          if (dataDone) begin
            phase   <= PH_HDR;
            bitCnt  <= '0;
            strobeQ <= !isRead && isMatch;
            holdQ   <= isRead && isMatch;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.clear    = selS;
    ctl.shiftIn  = rise && (phase == PH_HDR || !isRead);
    ctl.shiftOut = rise && phase == PH_DATA && isRead;
    ctl.loadRd   = strobeQ && isRead && phase == PH_DATA;
    ctl.latchHdr = hdrDone;
  end

  assign regStrobe = strobeQ;
  assign busDatOe  = (phase == PH_DATA && isRead && isMatch) || holdQ;

  // R4/R5: access strobe lasts one cycle
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    regStrobe |=> !regStrobe);
  // R4: a read strobe comes at the very start of the data phase
  a_r4_read_fetch_early: assert property (@(posedge clk) disable iff (!rstN)
    (regStrobe && isRead) |-> (phase == PH_DATA && bitCnt == '0));
  // R5: a write strobe comes only after the data phase is over
  a_r5_write_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (regStrobe && !isRead) |-> (phase == PH_HDR && bitCnt == '0));
  // R6: the end of the data phase returns to header reception
  a_r6_back_to_header: assert property (@(posedge clk) disable iff (!rstN)
    dataDone |=> (phase == PH_HDR && bitCnt == '0));
  // R1: a high select idles the bus side and releases the pin
  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rstN)
    selS |=> (phase == PH_HDR && bitCnt == '0 && !busDatOe));
  // R7: the pin is driven only for a matching device
  a_r7_drive_only_match: assert property (@(posedge clk) disable iff (!rstN)
    busDatOe |-> isMatch);
endmodule

// File: rtl/twr_dpath.sv
module twr_dpath
  import twr_pkg::*;
#(
  parameter int HDR_BITS = 9,
  parameter int DATA_BITS = 16,
  parameter int DEV_BITS = 3,
  parameter int REG_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic                 datS,
  input  logic [DATA_BITS-1:0] regRdata,
  output logic [DEV_BITS-1:0]  hdrDev,
  output logic                 hdrRd,
  output logic [DEV_BITS-1:0]  regDev,
  output logic [REG_BITS-1:0]  regIdx,
  output logic                 regRead,
  output logic [DATA_BITS-1:0] regWdata,
  output logic                 busDatOut
);
  logic [DATA_BITS-1:0] shiftQ;
  logic [HDR_BITS-1:0]  hdrWord;
  logic                 outQ;

  assign hdrWord = {shiftQ[HDR_BITS-2:0], datS};
  assign hdrDev  = hdrWord[HDR_BITS-1 -: DEV_BITS];
  assign hdrRd   = hdrWord[REG_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      outQ    <= 1'b0;
      regDev  <= '0;
      regIdx  <= '0;
      regRead <= 1'b0;
    end else begin
      if (ctl.clear) begin
        shiftQ <= '0;
        outQ   <= 1'b0;
      end else if (ctl.loadRd) begin
        shiftQ <= regRdata;
      end else if (ctl.shiftIn) begin
        shiftQ <= {shiftQ[DATA_BITS-2:0], datS};
      end else if (ctl.shiftOut) begin
        outQ   <= shiftQ[DATA_BITS-1];
        shiftQ <= {shiftQ[DATA_BITS-2:0], 1'b0};
      end
      if (ctl.latchHdr) begin
        regDev  <= hdrDev;
        regRead <= hdrRd;
        regIdx  <= hdrWord[REG_BITS-1:0];
      end
    end
  end

  assign regWdata  = shiftQ;
  assign busDatOut = outQ;

  // R1: a high select leaves a cleared shift value and a low output bit
  a_r1_clear_shift: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (shiftQ == '0 && !busDatOut));
  // R4: the word fetched at the read strobe is the one that gets shifted out
  a_r4_fetch_loaded: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadRd |=> (shiftQ == $past(regRdata)));
endmodule

// File: rtl/twr_slave.sv
module twr_slave
  import twr_pkg::*;
#(
  parameter int DEV_BITS = 3,
  parameter int REG_BITS = 5,
  parameter int DATA_BITS = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [DEV_BITS-1:0] DEV_ID = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busClk,
  input  logic                 busDatIn,
  output logic                 busDatOut,
  output logic                 busDatOe,
  output logic [DEV_BITS-1:0]  regDev,
  output logic [REG_BITS-1:0]  regIdx,
  output logic                 regRead,
  output logic [DATA_BITS-1:0] regWdata,
  input  logic [DATA_BITS-1:0] regRdata,
  output logic                 regStrobe
);
  localparam int HDR_BITS = DEV_BITS + 1 + REG_BITS;

  logic [2:0] pinsS;
  logic       selS, clkS, datS;
  dpCtl_t     ctl;
  logic [DEV_BITS-1:0] hdrDev;
  logic       hdrRd;

  twr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN), .din({busSel, busClk, busDatIn}), .dout(pinsS));
  assign {selS, clkS, datS} = pinsS;

  twr_ctrl #(.HDR_BITS(HDR_BITS), .DATA_BITS(DATA_BITS), .DEV_BITS(DEV_BITS),
             .DEV_ID(DEV_ID)) uCtrl (
    .clk(clk), .rstN(rstN), .selS(selS), .clkS(clkS), .hdrDev(hdrDev),
    .hdrRd(hdrRd), .ctl(ctl), .regStrobe(regStrobe), .busDatOe(busDatOe));

  twr_dpath #(.HDR_BITS(HDR_BITS), .DATA_BITS(DATA_BITS), .DEV_BITS(DEV_BITS),
              .REG_BITS(REG_BITS)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .datS(datS), .regRdata(regRdata),
    .hdrDev(hdrDev), .hdrRd(hdrRd), .regDev(regDev), .regIdx(regIdx),
    .regRead(regRead), .regWdata(regWdata), .busDatOut(busDatOut));
endmodule

// File: tb/tb_twr_slave.sv
`timescale 1ns/1ps
module tb_twr_slave;
  localparam int HALF = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 1'b1, busClk = 1'b0, busDatIn = 1'b0;
  logic busDatOut, busDatOe, regRead, regStrobe;
  logic [2:0]  regDev;
  logic [4:0]  regIdx;
  logic [15:0] regWdata, regRdata;

  int checks = 0, failures = 0;
  int strobeCnt = 0, oeCnt = 0;
  logic [2:0] lastDev;
  logic [4:0] lastIdx;
  logic       lastRead;
  logic [15:0] mem [32];
  logic [15:0] expMem [32];

  always #5 clk = ~clk;

  twr_slave dut (.clk(clk), .rstN(rstN), .busSel(busSel), .busClk(busClk),
    .busDatIn(busDatIn), .busDatOut(busDatOut), .busDatOe(busDatOe),
    .regDev(regDev), .regIdx(regIdx), .regRead(regRead), .regWdata(regWdata),
    .regRdata(regRdata), .regStrobe(regStrobe));

  function automatic logic [15:0] initVal(int i);
    return 16'h5A00 ^ (16'(i) * 16'h0111);
  endfunction

  // attached register file model
  assign regRdata = mem[regIdx];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) mem[i] <= initVal(i);
    end else if (regStrobe) begin
      strobeCnt <= strobeCnt + 1;
      lastDev <= regDev; lastIdx <= regIdx; lastRead <= regRead;
      if (!regRead) mem[regIdx] <= regWdata;
    end
    if (busDatOe) oeCnt <= oeCnt + 1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busBit(input logic b, input logic noisy, output logic got);
    busDatIn = b;
    waitCyc(HALF);
    busClk = 1'b1;
    if (noisy) begin
      waitCyc(3); busDatIn = ~b; waitCyc(HALF - 3);
    end else waitCyc(HALF);
    got = busDatOut;
    busClk = 1'b0;
  endtask

  task automatic frame(input logic rd, input logic [2:0] dev, input logic [4:0] idx,
                       input logic [15:0] wd, input logic noisy, output logic [15:0] rdat);
    logic [8:0] hdr;
    logic g;
    hdr = {dev, rd, idx};
    rdat = '0;
    for (int i = 8; i >= 0; i--) busBit(hdr[i], 1'b0, g);
    for (int i = 15; i >= 0; i--) begin
      busBit(rd ? 1'b0 : wd[i], noisy, g);
      rdat = {rdat[14:0], g};
    end
    busDatIn = 1'b0;
    waitCyc(4);
  endtask

  // {read, device, register index, write data}
  localparam logic [24:0] VEC [10] = '{
    {1'b0, 3'd1, 5'd3,  16'hA5C3},
    {1'b1, 3'd1, 5'd3,  16'h0000},
    {1'b0, 3'd1, 5'd31, 16'h8001},
    {1'b1, 3'd1, 5'd31, 16'h0000},
    {1'b0, 3'd2, 5'd3,  16'h1234},
    {1'b1, 3'd1, 5'd3,  16'h0000},
    {1'b1, 3'd5, 5'd0,  16'h0000},
    {1'b0, 3'd1, 5'd0,  16'hFFFF},
    {1'b1, 3'd1, 5'd0,  16'h0000},
    {1'b1, 3'd1, 5'd17, 16'h0000}
  };

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] rdat;
    int s0, o0;
    for (int i = 0; i < 32; i++) expMem[i] = initVal(i);
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(4);
    chk("R1 reset oe", 32'(busDatOe), 32'd0);
    chk("R1 reset strobe", 32'(regStrobe), 32'd0);

    // table of frames
    for (int v = 0; v < 10; v++) begin
      logic rd, match;
      logic [2:0] dev;
      logic [4:0] idx;
      logic [15:0] wd;
      {rd, dev, idx, wd} = VEC[v];
      match = (dev == 3'd1);
      s0 = strobeCnt; o0 = oeCnt;
      busSel = 1'b0; waitCyc(4);
      frame(rd, dev, idx, wd, 1'b0, rdat);
      busSel = 1'b1; waitCyc(6);
      chk(match ? "R3 strobe count" : "R7 strobe count", 32'(strobeCnt - s0), match ? 32'd1 : 32'd0);
      if (match) chk("R3 header fields", {23'd0, lastDev, lastRead, lastIdx}, {23'd0, dev, rd, idx});
      if (rd) begin
        chk(match ? "R4 read oe" : "R7 read oe", 32'(oeCnt != o0), 32'(match));
        if (match) chk("R4 read data", 32'(rdat), 32'(expMem[idx]));
      end else begin
        if (match) expMem[idx] = wd;
        chk(match ? "R5 write data" : "R7 no write", 32'(mem[idx]), 32'(expMem[idx]));
      end
    end

    // R1: frame aborted in its data phase by select
    s0 = strobeCnt;
    busSel = 1'b0; waitCyc(4);
    begin
      logic [8:0] hdr;
      logic g;
      hdr = {3'd1, 1'b0, 5'd5};
      for (int i = 8; i >= 0; i--) busBit(hdr[i], 1'b0, g);
      for (int i = 0; i < 8; i++) busBit(1'b1, 1'b0, g);
    end
    busSel = 1'b1; waitCyc(8);
    chk("R1 aborted frame no strobe", 32'(strobeCnt - s0), 32'd0);
    chk("R1 aborted frame no write", 32'(mem[5]), 32'(expMem[5]));
    busSel = 1'b0; waitCyc(4);
    frame(1'b0, 3'd1, 5'd5, 16'h0F0F, 1'b0, rdat);
    busSel = 1'b1; waitCyc(6);
    expMem[5] = 16'h0F0F;
    chk("R1 fresh frame after abort", 32'(mem[5]), 32'h0F0F);

    // R6/R8: two frames in one select window, then pin hold
    s0 = strobeCnt;
    busSel = 1'b0; waitCyc(4);
    frame(1'b0, 3'd1, 5'd7, 16'hBEEF, 1'b0, rdat);
    frame(1'b1, 3'd1, 5'd7, 16'h0000, 1'b0, rdat);
    expMem[7] = 16'hBEEF;
    chk("R6 back-to-back read", 32'(rdat), 32'hBEEF);
    chk("R6 back-to-back strobes", 32'(strobeCnt - s0), 32'd2);
    chk("R8 pin held after last bit", 32'(busDatOe), 32'd1);
    begin
      logic g;
      busBit(1'b0, 1'b0, g);
    end
    chk("R8 pin released on next edge", 32'(busDatOe), 32'd0);
    busSel = 1'b1; waitCyc(6);
    chk("R1 released after deselect", 32'(busDatOe), 32'd0);

    // R2: data wiggling between rising edges
    busSel = 1'b0; waitCyc(4);
    frame(1'b0, 3'd1, 5'd9, 16'h3C96, 1'b1, rdat);
    busSel = 1'b1; waitCyc(6);
    expMem[9] = 16'h3C96;
    chk("R2 noisy write captured", 32'(mem[9]), 32'h3C96);
    busSel = 1'b0; waitCyc(4);
    frame(1'b1, 3'd1, 5'd9, 16'h0000, 1'b0, rdat);
    busSel = 1'b1; waitCyc(6);
    chk("R2 noisy write read back", 32'(rdat), 32'h3C96);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule